// File: doc/BRIEF.md
# Channel-to-Word Corner-Turn Buffer

This block collects data arriving on many independent serial channels and regroups it into whole words for a parallel store. Each channel delivers one bit per bit time. At every bit time, all channels are sampled together and the sample is written as one row of a square bit array. After as many rows as there are channels have been written, the array holds one complete transfer. It is then read out column by column. A column gathers the successive bits of one channel, so the bits of that channel become adjacent in the output words.

There are two arrays used in ping-pong fashion. Capture into one array continues while the other array drains through a valid/ready word port. Each column is longer than one word, so it leaves as several consecutive words. With the default sizes (100 channels, 50-bit words) a column is sent as a pair of words, and a full array is 200 words. A sample that arrives while both arrays are full is dropped and flagged. A one-cycle pulse marks the acceptance of the last word of an array.

Top module: `ct_corner_turn`

## Requirements
- R1: While reset is active and in the first cycle after it, `word_valid`, `overflow` and `frame_done` are low, and the row, column and bank counters start at zero.
- R2: Each cycle with `ch_valid` high and a free array writes `ch_bits` as the next row. After N_CH accepted samples, the array is complete and `word_valid` rises in the following cycle.
- R3: A sample presented while both arrays are full is discarded, and `overflow` is high for exactly the next cycle. Arrays that are already full are unaffected.
- R4: Words of an array leave in column order, columns 0 to N_CH-1. Within column c, the word with sub-index h (0 first) has bit i equal to channel c's bit from accepted sample number h*WORD_W+i of that array.
- R5: While `word_valid` is high and `word_ready` is low, `word_valid` stays high and `word_data` stays unchanged in the next cycle.
- R6: `frame_done` is high for exactly one cycle, in the cycle after the last word of an array is accepted.
- R7: Capture into the second array proceeds while the first one drains, with no sample lost and no gap in the output word order.
- R8: A reset during a partly filled array discards those rows. The first array completed after reset contains only post-reset samples.
- R9: Arrays drain in the order in which they were completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_bits | input | N_CH | One bit from every channel for the current bit time |
| ch_valid | input | 1 | `ch_bits` holds a sample this cycle |
| word_data | output | WORD_W | Current output word |
| word_valid | output | 1 | `word_data` is available |
| word_ready | input | 1 | Consumer accepts the word this cycle |
| overflow | output | 1 | Pulse: a sample was dropped because both arrays were full |
| frame_done | output | 1 | Pulse: the last word of an array was accepted |

## Verification
The bench targets the moment an array fills while the other is still draining. A design that releases the wrong bank there would repeat an old array or skip a new one. It sends a burst long enough to overrun both arrays with the consumer stalled. A design with a misplaced overflow test would either corrupt a full array or drop samples that had room. Random back-pressure checks that a stalled word neither changes nor advances. A transposition with the wrong sub-index or column stride shows up as a word miscompare against the model. A reset in the middle of a fill checks that leftover rows do not leak into the next array.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int CT_CHANNELS_DEF = 100;
  localparam int CT_WORD_W_DEF   = 50;

  typedef logic [1:0] bank_vec_t;

  function automatic int ct_idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ct_capture.sv
module ct_capture
  import ct_pkg::*;
#(
  parameter int N_CH = CT_CHANNELS_DEF,
  localparam int ROW_W = ct_idx_w(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_valid,
  input  bank_vec_t        bank_full,
  output logic             wr_en,
  output logic             wr_bank,
  output logic [ROW_W-1:0] wr_row,
  output logic             fill_done,
  output logic             overflow
);
  logic [ROW_W-1:0] row_q, row_d;
  logic             bank_q, bank_d;
  logic             ovf_q, ovf_d;
  logic             room;

  always_comb begin
    room      = !bank_full[bank_q];
    wr_en     = ch_valid && room;
    fill_done = wr_en && (row_q == ROW_W'(N_CH - 1));
    row_d     = row_q;
    bank_d    = bank_q;
    if (wr_en) row_d = fill_done ? '0 : row_q + 1'b1;
    if (fill_done) bank_d = !bank_q;
    ovf_d     = ch_valid && !room;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      bank_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      row_q  <= row_d;
      bank_q <= bank_d;
      ovf_q  <= ovf_d;
    end
  end

  assign wr_bank  = bank_q;
  assign wr_row   = row_q;
  assign overflow = ovf_q;

  // R3: a drop pulse follows a presented sample
  p_ovf_from_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(ch_valid));
endmodule

// File: rtl/ct_store.sv
module ct_store
  import ct_pkg::*;
#(
  parameter int N_CH   = CT_CHANNELS_DEF,
  parameter int WORD_W = CT_WORD_W_DEF,
  localparam int ROW_W  = ct_idx_w(N_CH),
  localparam int WPC    = N_CH / WORD_W,
  localparam int HALF_W = ct_idx_w(WPC)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [N_CH-1:0]   wr_data,
  input  logic              rd_bank,
  input  logic [ROW_W-1:0]  rd_col,
  input  logic [HALF_W-1:0] rd_sub,
  output logic [WORD_W-1:0] rd_word
);
  logic [N_CH-1:0] mem [2][N_CH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_bank][wr_row] <= wr_data;
  end

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    logic [ROW_W-1:0] ridx;
    assign ridx       = ROW_W'(32'(rd_sub) * WORD_W + i);
    assign rd_word[i] = mem[rd_bank][ridx][rd_col];
  end
endmodule

// File: rtl/ct_drain.sv
module ct_drain
  import ct_pkg::*;
#(
  parameter int N_CH   = CT_CHANNELS_DEF,
  parameter int WORD_W = CT_WORD_W_DEF,
  localparam int ROW_W  = ct_idx_w(N_CH),
  localparam int WPC    = N_CH / WORD_W,
  localparam int HALF_W = ct_idx_w(WPC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_vec_t         bank_full,
  input  logic              word_ready,
  output logic              rd_bank,
  output logic [ROW_W-1:0]  rd_col,
  output logic [HALF_W-1:0] rd_sub,
  output logic              word_valid,
  output logic              drain_done,
  output logic              frame_done
);
  logic [ROW_W-1:0]  col_q, col_d;
  logic [HALF_W-1:0] sub_q, sub_d;
  logic              bank_q, bank_d;
  logic              done_q;
  logic              take, sub_last;

  always_comb begin
    word_valid = bank_full[bank_q];
    take       = word_valid && word_ready;
    sub_last   = (sub_q == HALF_W'(WPC - 1));
    drain_done = take && sub_last && (col_q == ROW_W'(N_CH - 1));
    col_d      = col_q;
    sub_d      = sub_q;
    bank_d     = bank_q;
    if (take) begin
      if (sub_last) begin
        sub_d = '0;
        col_d = drain_done ? '0 : col_q + 1'b1;
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
    if (drain_done) bank_d = !bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      sub_q  <= '0;
      bank_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      col_q  <= col_d;
      sub_q  <= sub_d;
      bank_q <= bank_d;
      done_q <= drain_done;
    end
  end

  assign rd_bank    = bank_q;
  assign rd_col     = col_q;
  assign rd_sub     = sub_q;
  assign frame_done = done_q;

  // R6: completion pulse only after an accepted word
  p_done_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(word_valid && word_ready));
endmodule

// File: rtl/ct_corner_turn.sv
module ct_corner_turn
  import ct_pkg::*;
#(
  parameter int N_CH   = CT_CHANNELS_DEF,
  parameter int WORD_W = CT_WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   ch_bits,
  input  logic              ch_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  input  logic              word_ready,
  output logic              overflow,
  output logic              frame_done
);
  localparam int ROW_W  = ct_idx_w(N_CH);
  localparam int WPC    = N_CH / WORD_W;
  localparam int HALF_W = ct_idx_w(WPC);

  bank_vec_t         full_q, full_d;
  logic              wr_en, wr_bank, fill_done;
  logic [ROW_W-1:0]  wr_row;
  logic              rd_bank, drain_done;
  logic [ROW_W-1:0]  rd_col;
  logic [HALF_W-1:0] rd_sub;

  ct_capture #(.N_CH(N_CH)) u_cap (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .bank_full(full_q),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_row(wr_row),
    .fill_done(fill_done), .overflow(overflow)
  );

  ct_store #(.N_CH(N_CH), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_row(wr_row),
    .wr_data(ch_bits), .rd_bank(rd_bank), .rd_col(rd_col),
    .rd_sub(rd_sub), .rd_word(word_data)
  );

  ct_drain #(.N_CH(N_CH), .WORD_W(WORD_W)) u_drn (
    .clk(clk), .rst_n(rst_n), .bank_full(full_q), .word_ready(word_ready),
    .rd_bank(rd_bank), .rd_col(rd_col), .rd_sub(rd_sub),
    .word_valid(word_valid), .drain_done(drain_done), .frame_done(frame_done)
  );

  always_comb begin
    full_d = full_q;
    if (fill_done)  full_d[wr_bank] = 1'b1;
    if (drain_done) full_d[rd_bank] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= '0;
    else        full_q <= full_d;
  end

  // R5: a stalled word holds
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

  // R3: drops happen only with both arrays occupied
  p_drop_only_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(full_q == 2'b11));
endmodule

// File: tb/sim_ct_corner_turn.sv
`timescale 1ns/1ps
module sim_ct_corner_turn;
  localparam int NC  = 100;
  localparam int WW  = 50;
  localparam int WPF = NC * (NC / WW);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NC-1:0] ch_bits;
  logic          ch_valid;
  logic [WW-1:0] word_data;
  logic          word_valid;
  logic          word_ready;
  logic          overflow;
  logic          frame_done;

  ct_corner_turn #(.N_CH(NC), .WORD_W(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_bits(ch_bits), .ch_valid(ch_valid),
    .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
    .overflow(overflow), .frame_done(frame_done)
  );

  always #2.5 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  logic [NC-1:0] rows [$];
  logic [WW-1:0] wq   [$];
  int  dcnt = 0;
  bit  exp_ovf = 0, exp_done = 0;
  string tag = "R4";

  task automatic fail(string req, string what, logic [63:0] act, logic [63:0] exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  function automatic int frames_held();
    return (wq.size() + (WPF - dcnt) % WPF + WPF - 1) / WPF;
  endfunction

  task automatic compare();
    bit ev;
    vectors++;
    ev = (wq.size() > 0);
    if (word_valid !== ev) fail("R2/R7", "word_valid", 64'(word_valid), 64'(ev));
    if (ev && word_valid && word_data !== wq[0])
      fail(tag, "word_data", 64'(word_data), 64'(wq[0]));
    if (overflow !== exp_ovf) fail("R3", "overflow", 64'(overflow), 64'(exp_ovf));
    if (frame_done !== exp_done) fail("R6", "frame_done", 64'(frame_done), 64'(exp_done));
  endtask

  // one cycle: check, drive, predict, then advance to next negedge
  task automatic step(bit v, bit rdy);
    int  full_before;
    bit  hs;
    logic [NC-1:0] s;
    compare();
    s = {$urandom, $urandom, $urandom, $urandom};
    ch_bits = s; ch_valid = v; word_ready = rdy;
    full_before = (wq.size() + WPF - 1) / WPF;
    hs = rdy && (wq.size() > 0);
    exp_done = 0;
    if (hs) begin
      void'(wq.pop_front());
      dcnt++;
      if (dcnt == WPF) begin dcnt = 0; exp_done = 1; end
    end
    exp_ovf = v && (full_before == 2);
    if (v && full_before < 2) begin
      rows.push_back(s);
      if (rows.size() == NC) begin
        for (int c = 0; c < NC; c++)
          for (int h = 0; h < NC / WW; h++) begin
            logic [WW-1:0] w;
            for (int i = 0; i < WW; i++) w[i] = rows[h*WW + i][c];
            wq.push_back(w);
          end
        rows.delete();
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ch_valid = 0; word_ready = 0; ch_bits = '0;
    rows.delete(); wq.delete(); dcnt = 0; exp_ovf = 0; exp_done = 0;
    repeat (3) @(negedge clk);
    vectors++;
    if (word_valid !== 0 || overflow !== 0 || frame_done !== 0)
      fail("R1", "outputs in reset", 64'({word_valid, overflow, frame_done}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: idle after reset
    repeat (3) step(0, 1);
    // R2 R4: single array, gapped input, free consumer
    tag = "R4";
    for (int n = 0; n < 160; n++) step(($urandom % 4) != 0, 1);
    for (int n = 0; n < 260; n++) step(0, 1);
    // R3 R7: stalled consumer, overrun both arrays
    tag = "R7";
    for (int n = 0; n < 250; n++) step(1, 0);
    // R5 R9: random back-pressure while capture continues
    tag = "R9";
    for (int n = 0; n < 900; n++) step(($urandom % 2) != 0, ($urandom % 10) < 7);
    for (int n = 0; n < 700; n++) step(0, ($urandom % 10) < 6);
    // R8: reset in the middle of a fill
    for (int n = 0; n < 37; n++) step(1, 1);
    do_reset();
    tag = "R8";
    for (int n = 0; n < 100; n++) step(1, 1);
    for (int n = 0; n < 230; n++) step(0, 1);
    vectors++;
    if (word_valid !== 0) fail("R8", "leftover words", 64'(word_valid), 64'(0));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule